// File: doc/BRIEF.md
# Power Management Event Input Conditioner

This block turns three raw event inputs into one system-management interrupt request. The inputs are a lid switch, a power button and an external active-low interrupt request line. The lid and power button are slow mechanical contacts. Each passes through a two-flop synchroniser and then a debounce filter. The filter steps on a 1 ms tick input, so a debounced level changes only after the input has held one value for the whole debounce window.

The lid raises an event on every change of its debounced level. The power button raises an event only when it is pressed. The external request raises an event on its falling edge, and one clock of low level after synchronisation is enough. A second falling edge counts only after the line has been high again for a minimum number of clocks.

Each event sets a sticky status bit when its enable bit is set. Writing one to a status bit clears it. The active-low interrupt output is registered on the PCI clock. It is low for as long as any enabled status bit is set.

Top module: `pm_evt_cond`

## Requirements
- R1: After reset, `stat_o` is 000, `smi_no` is 1, and both debounced levels are 0.
- R2: A debounced level follows its synchronised input only on the 16th consecutive tick with the input different from the level. 15 such ticks leave the level unchanged, and a return to the old value restarts the count.
- R3: Every change of the debounced lid level, rising or falling, sets status bit 0 when `en_i[0]` is set.
- R4: A rise of the debounced power-button level (press, `pwrbtn_i`=1) sets status bit 1 when `en_i[1]` is set. A fall (release) sets no status bit.
- R5: A falling edge of `ext_smi_ni` sets status bit 2 when `en_i[2]` is set. One clock of low level is enough.
- R6: After `ext_smi_ni` goes high, a new falling edge counts only if the synchronised line was high for at least 4 consecutive clocks before it. 3 clocks are not enough.
- R7: An event whose enable bit is clear leaves its status bit unchanged.
- R8: A 1 in `clr_i` clears the matching status bit and leaves the other bits set. An event in the same cycle as a clear takes precedence, and the bit stays set.
- R9: `smi_no` is a register on `clk_i`. It is 0 exactly when the previous cycle had `stat_o & en_i` nonzero. Clearing an enable therefore releases the output while the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-clock pulse every millisecond |
| lid_i | input | 1 | Raw lid switch, asynchronous |
| pwrbtn_i | input | 1 | Raw power button, 1 = pressed, asynchronous |
| ext_smi_ni | input | 1 | External interrupt request, active low, asynchronous |
| en_i | input | 3 | Per-source enable: bit0 lid, bit1 power button, bit2 external |
| clr_i | input | 3 | Write-one-to-clear strobe for status, same bit order |
| stat_o | output | 3 | Sticky status, same bit order |
| lid_lvl_o | output | 1 | Debounced lid level |
| pwrbtn_lvl_o | output | 1 | Debounced power-button level |
| smi_no | output | 1 | Interrupt request, active low, registered |

## Verification
The embedded properties assume that `ms_tick_i` is a single-clock pulse. They also assume that `en_i` and `clr_i` are synchronous to `clk_i` and free of X from reset onward. The stimulus drives every input on the falling clock edge and holds `en_i` and `clr_i` at zero from time zero. It spaces tick pulses with at least one idle clock between them. The external request is held high for known clock counts so that the re-arm window is hit exactly at 3 and 4 clocks. Enable changes are placed between the status update of one external event and that of the next.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned NUM_SLOW = 2;
  localparam int unsigned SRC_LID  = 0;
  localparam int unsigned SRC_PWR  = 1;
  localparam int unsigned SRC_EXT  = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/pm_evt_sync.sv
module pm_evt_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pm_evt_debounce.sv
module pm_evt_debounce #(
  parameter int unsigned TICKS      = 16,
  parameter bit          BOTH_EDGES = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic lvl_o,
  output logic evt_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q, evt_q, flip, evt_d;

  assign flip = (d_i != lvl_q) && tick_i && (cnt_q == LAST);

  generate
    if (BOTH_EDGES) begin : g_both
      assign evt_d = flip;
    end else begin : g_rise
      assign evt_d = flip && d_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      if (d_i == lvl_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          lvl_q <= d_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign lvl_o = lvl_q;
  assign evt_o = evt_q;

  // level may only move on a tick edge
  p_lvl_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(tick_i));
  // an event always coincides with a level change
  p_evt_has_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> !$stable(lvl_q));
endmodule

// File: rtl/pm_evt_fall_rearm.sv
module pm_evt_fall_rearm #(
  parameter int unsigned REARM = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic evt_o
);
  localparam int unsigned HW = $clog2(REARM + 1);
  localparam logic [HW-1:0] FULL = HW'(REARM);

  logic [HW-1:0] hi_cnt_q;
  logic          armed, evt_q;

  assign armed = (hi_cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= !s_i && armed;
      if (!s_i)        hi_cnt_q <= '0;
      else if (!armed) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign evt_o = evt_q;

  // re-arm needs high time, so events never come back to back
  p_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  // an event follows a low sample
  p_evt_after_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> !$past(s_i));
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t en_i,
  input  src_vec_t clr_i,
  output src_vec_t st_o,
  output logic     smi_no
);
  src_vec_t st_q;
  logic     smi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      smi_q <= 1'b1;
    end else begin
      st_q  <= (st_q & ~clr_i) | (evt_i & en_i);  // set beats clear
      smi_q <= ~|(st_q & en_i);
    end
  end

  assign st_o   = st_q;
  assign smi_no = smi_q;

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_i)) == '0));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & $past(clr_i & ~evt_i)) == '0));
  p_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~st_q & $past(st_q & ~clr_i)) == '0));
  p_smi_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_q |-> $past(|st_q));
endmodule

// File: rtl/pm_evt_cond.sv
module pm_evt_cond
  import pm_evt_pkg::*;
#(
  parameter int unsigned DB_TICKS    = 16,
  parameter int unsigned EXT_REARM   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ms_tick_i,
  input  logic           lid_i,
  input  logic           pwrbtn_i,
  input  logic           ext_smi_ni,
  input  logic [2:0]     en_i,
  input  logic [2:0]     clr_i,
  output logic [2:0]     stat_o,
  output logic           lid_lvl_o,
  output logic           pwrbtn_lvl_o,
  output logic           smi_no
);
  logic [NUM_SLOW-1:0] slow_raw, slow_s, slow_lvl, slow_evt;
  logic                ext_s, ext_evt;
  src_vec_t            evt;

  assign slow_raw[SRC_LID] = lid_i;
  assign slow_raw[SRC_PWR] = pwrbtn_i;

  pm_evt_sync #(.WIDTH(NUM_SLOW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_slow (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(slow_raw), .q_o(slow_s)
  );

  pm_evt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ext (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ext_smi_ni), .q_o(ext_s)
  );

  generate
    for (genvar j = 0; j < NUM_SLOW; j++) begin : g_db
      pm_evt_debounce #(
        .TICKS     (DB_TICKS),
        .BOTH_EDGES(j == SRC_LID)
      ) u_db (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(ms_tick_i),
        .d_i   (slow_s[j]),
        .lvl_o (slow_lvl[j]),
        .evt_o (slow_evt[j])
      );
    end
  endgenerate

  pm_evt_fall_rearm #(.REARM(EXT_REARM)) u_ext (
    .clk_i (clk_i), .rst_ni(rst_ni), .s_i(ext_s), .evt_o(ext_evt)
  );

  assign evt = {ext_evt, slow_evt};

  pm_evt_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .en_i  (en_i),
    .clr_i (clr_i),
    .st_o  (stat_o),
    .smi_no(smi_no)
  );

  assign lid_lvl_o    = slow_lvl[SRC_LID];
  assign pwrbtn_lvl_o = slow_lvl[SRC_PWR];

  // power button press is rising only
  p_pwr_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_evt[SRC_PWR] |-> slow_lvl[SRC_PWR]);
endmodule

// File: tb/pm_evt_cond_tb_top.sv
`timescale 1ns/1ps
module pm_evt_cond_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, lid = 1'b0, pwr = 1'b0, ext_n = 1'b1;
  logic [2:0] en = 3'b000, clr = 3'b000;
  logic [2:0] stat;
  logic       lid_lvl, pwr_lvl, smi_n;
  int         n_chk = 0, n_err = 0;
  logic       lid_v = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pm_evt_cond dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .lid_i(lid),
    .pwrbtn_i(pwr), .ext_smi_ni(ext_n), .en_i(en), .clr_i(clr),
    .stat_o(stat), .lid_lvl_o(lid_lvl), .pwrbtn_lvl_o(pwr_lvl), .smi_no(smi_n)
  );

  // fields: [7:6] source (0 lid, 1 pwr, 2 ext), [5:3] enable, [2:0] expected status
  localparam logic [7:0] VECS [9] = '{
    {2'd2, 3'b111, 3'b100},
    {2'd0, 3'b001, 3'b001},
    {2'd0, 3'b001, 3'b001},
    {2'd1, 3'b010, 3'b010},
    {2'd0, 3'b110, 3'b000},
    {2'd2, 3'b011, 3'b000},
    {2'd1, 3'b101, 3'b000},
    {2'd2, 3'b100, 3'b100},
    {2'd0, 3'b111, 3'b001}
  };

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic clear_all();
    clr = 3'b111; @(negedge clk);
    clr = 3'b000; cyc(2);
  endtask

  task automatic lid_toggle();
    lid_v = ~lid_v; lid = lid_v; cyc(3); ticks(16); cyc(3);
  endtask

  task automatic pwr_set(logic v);
    pwr = v; cyc(3); ticks(16); cyc(3);
  endtask

  task automatic ext_pulse();
    ext_n = 1'b0; @(negedge clk);
    ext_n = 1'b1; cyc(8);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk("R1 status", stat, 3'b000);
    chk("R1 smi", {2'b0, smi_n}, 3'b001);
    chk("R1 levels", {1'b0, pwr_lvl, lid_lvl}, 3'b000);
    rst_n = 1'b1;
    cyc(8);

    // table walk: R3 R4 R5 R7 R9
    foreach (VECS[k]) begin
      en = VECS[k][5:3];
      case (VECS[k][7:6])
        2'd0: lid_toggle();
        2'd1: begin pwr_set(1'b1); pwr_set(1'b0); end
        default: ext_pulse();
      endcase
      chk($sformatf("R3/R4/R5/R7 vec%0d", k), stat, VECS[k][2:0]);
      chk($sformatf("R9 vec%0d smi", k), {2'b0, smi_n}, {2'b0, ~|(VECS[k][2:0] & VECS[k][5:3])});
      clear_all();
    end

    // R2 boundary: 15 ticks not enough, 16th flips
    en = 3'b001;
    lid_v = ~lid_v; lid = lid_v; cyc(3); ticks(15); cyc(3);
    chk("R2 15 ticks level", {2'b0, lid_lvl}, {2'b0, ~lid_v});
    chk("R2 15 ticks status", stat, 3'b000);
    ticks(1); cyc(3);
    chk("R2 16th tick level", {2'b0, lid_lvl}, {2'b0, lid_v});
    chk("R3 16th tick status", stat, 3'b001);
    clear_all();

    // R2 glitch restarts count
    lid = ~lid_v; cyc(3); ticks(10);
    lid = lid_v; cyc(3); ticks(4);
    lid = ~lid_v; cyc(3); ticks(8); cyc(3);
    chk("R2 glitch level", {2'b0, lid_lvl}, {2'b0, lid_v});
    chk("R2 glitch status", stat, 3'b000);
    ticks(8); cyc(3);
    lid_v = ~lid_v;
    chk("R2 after 16 level", {2'b0, lid_lvl}, {2'b0, lid_v});
    clear_all();

    // R4 release alone sets nothing
    en = 3'b010;
    pwr_set(1'b1);
    chk("R4 press", stat, 3'b010);
    clear_all();
    pwr_set(1'b0);
    chk("R4 release status", stat, 3'b000);
    chk("R4 release level", {2'b0, pwr_lvl}, 3'b000);

    // R6 re-arm: 3 high clocks rejected
    en = 3'b011; ext_n = 1'b0; @(negedge clk);
    ext_n = 1'b1; cyc(3);
    ext_n = 1'b0; @(negedge clk);
    ext_n = 1'b1; en = 3'b111; cyc(8);
    chk("R6 3 high clocks", stat, 3'b000);
    // 4 high clocks accepted
    en = 3'b011; ext_n = 1'b0; @(negedge clk);
    ext_n = 1'b1; cyc(4);
    ext_n = 1'b0; @(negedge clk);
    ext_n = 1'b1; en = 3'b111; cyc(8);
    chk("R6 4 high clocks", stat, 3'b100);
    clear_all();

    // R8 selective clear
    en = 3'b111;
    lid_toggle(); ext_pulse();
    chk("R8 both set", stat, 3'b101);
    clr = 3'b001; @(negedge clk);
    clr = 3'b000; cyc(2);
    chk("R8 selective clear", stat, 3'b100);
    chk("R9 smi held", {2'b0, smi_n}, 3'b000);

    // R9 enable drop releases output, status kept
    en = 3'b011; cyc(2);
    chk("R9 smi released", {2'b0, smi_n}, 3'b001);
    chk("R9 status kept", stat, 3'b100);
    clear_all();

    done = 1'b1;
    finish_run();
  end
endmodule